// File: doc/BRIEF.md
# External Interrupt Polarity Normalizer

This block sits between a set of external interrupt pins and a parent interrupt controller that only understands two kinds of request: an active-high level and a rising edge. Each pin has its own configuration word, written over a simple 32-bit register bus. The word enables or masks the channel, chooses between level and edge sensitivity, and gives the polarity of the pin. The block synchronizes each asynchronous pin, corrects its polarity, and forwards one registered request line per channel.

A level-sensitive channel drives its request high for as long as the pin sits at its active level, whether that level is high or low. An edge-sensitive channel produces a single-cycle high pulse for each qualifying transition, whether the pin was set up for rising or falling edges. Writing a channel's configuration with a new value clears that channel's edge history, so reprogramming never produces a pulse of its own.

Top module: `irq_polarity_norm`

## Requirements
- R1: After reset every channel configuration word reads 0 (channel disabled) and every request output is low.
- R2: The configuration word of channel x sits at byte address 4 + 4*x. Only bit 16 (enable), bit 9 (1 = level, 0 = edge) and bit 8 (polarity) are stored; every other bit reads 0 whatever was written. A read returns its data on the bus one clock after the read strobe, and the data bus is 0 in every cycle that follows a clock without a read.
- R3: Address 0x0, addresses beyond the last channel and addresses that are not a multiple of 4 read 0, and writes to them change no channel configuration.
- R4: With enable=1, bit 9=1, bit 8=1 (level, active high), the request is high while the pin is high; a pin change appears at the output on the third rising clock edge after it.
- R5: With enable=1, bit 9=1, bit 8=0 (level, active low), the request is high while the pin is low, with the same three-edge latency.
- R6: With enable=1, bit 9=0, bit 8=0 (rising edge), each low-to-high pin transition gives a request pulse of exactly one clock, on the third edge after the transition; high-to-low transitions give nothing.
- R7: With enable=1, bit 9=0, bit 8=1 (falling edge), each high-to-low pin transition gives a one-clock request pulse with the same latency; low-to-high transitions give nothing.
- R8: With enable=0 the request output stays low in both level and edge mode, whatever the pin does.
- R9: A write that changes a channel's configuration produces no edge pulse of its own, even when the new polarity makes the current pin state look active.
- R10: Channels are independent: the pin and configuration of one channel never affect the request of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_irq | input | NCH | Asynchronous external interrupt pins |
| irq_out | output | NCH | Active-high requests to the parent controller |

## Verification
Assertions watch, on every cycle, that an edge-mode request never lasts longer than one clock, that a masked channel never raises its request, that a configuration change in edge mode is followed by a quiet output, that reserved bits read zero and that the data bus is zero after idle cycles. The exact three-edge latency, the correct polarity for each of the four trigger types, the absence of pulses on the wrong edge, the address decode of unmapped and misaligned accesses and the independence of the two channels can only be shown by the bench's scenarios, which predict each output cycle from the requirements.

// File: rtl/irqn_pkg.sv
package irqn_pkg;

  localparam int DATA_W  = 32;
  localparam int EN_BIT  = 16;
  localparam int LVL_BIT = 9;
  localparam int POL_BIT = 8;

  typedef struct packed {
    logic en;
    logic lvl;
    logic pol;
  } chan_cfg_t;

  localparam logic [DATA_W-1:0] CFG_MASK =
    (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << LVL_BIT) | (DATA_W'(1) << POL_BIT);

  function automatic logic [DATA_W-1:0] cfg_to_word(chan_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT]  = c.en;
    w[LVL_BIT] = c.lvl;
    w[POL_BIT] = c.pol;
    return w;
  endfunction

  function automatic chan_cfg_t word_to_cfg(logic [DATA_W-1:0] w);
    chan_cfg_t c;
    c.en  = w[EN_BIT];
    c.lvl = w[LVL_BIT];
    c.pol = w[POL_BIT];
    return c;
  endfunction

endpackage

// File: rtl/irqn_sync.sv
module irqn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/irqn_regs.sv
module irqn_regs
  import irqn_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output chan_cfg_t [NCH-1:0]    cfg_o,
  output logic [NCH-1:0]         chg_o
);
  localparam int STRIDE = 4;
  localparam int FIRST  = 4;

  chan_cfg_t [NCH-1:0] cfg_q;
  logic      [NCH-1:0] chg_q;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   rdata_q;
  chan_cfg_t           wr_cfg;

  assign wr_cfg = word_to_cfg(wdata_i);

  for (genvar i = 0; i < NCH; i++) begin : g_cfg
    logic sel;
    assign sel = wr_i && (addr_i == ADDR_W'(FIRST + STRIDE * i));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[i] <= '0;
        chg_q[i] <= 1'b0;
      end else begin
        chg_q[i] <= sel && (wr_cfg != cfg_q[i]);
        if (sel) cfg_q[i] <= wr_cfg;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == ADDR_W'(FIRST + STRIDE * i)) rd_mux = cfg_to_word(cfg_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
    else           rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
  assign cfg_o   = cfg_q;
  assign chg_o   = chg_q;

  // R2: reserved bit positions never carry data
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rdata_q & ~CFG_MASK) == '0);

  // R2: idle bus returns zero one clock later
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_q == '0));
endmodule

// File: rtl/irqn_chan.sv
module irqn_chan
  import irqn_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_i,
  input  chan_cfg_t cfg_i,
  input  logic      chg_i,
  output logic      irq_o
);
  logic pin_s;
  logic inv;
  logic act;
  logic hist_q;
  logic irq_q;

  irqn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_s)
  );

  // level: polarity 1 means active high; edge: polarity 1 means falling
  assign inv = cfg_i.lvl ? ~cfg_i.pol : cfg_i.pol;
  assign act = pin_s ^ inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      hist_q <= act;
      if (!cfg_i.en)     irq_q <= 1'b0;
      else if (cfg_i.lvl) irq_q <= act;
      else if (chg_i)     irq_q <= 1'b0;
      else                irq_q <= act & ~hist_q;
    end
  end

  assign irq_o = irq_q;

  // R6/R7: an edge request is a single-cycle pulse
  p_edge_single_r6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_i.lvl && irq_q) |=> !irq_q);

  // R8: a disabled channel keeps its request low
  p_masked_low_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_i.en |=> !irq_q);

  // R9: reconfiguring an edge channel is quiet
  p_reconfig_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (chg_i && !cfg_i.lvl) |=> !irq_q);
endmodule

// File: rtl/irq_polarity_norm.sv
module irq_polarity_norm
  import irqn_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    ext_irq,
  output logic [NCH-1:0]    irq_out
);
  chan_cfg_t [NCH-1:0] cfg;
  logic      [NCH-1:0] chg;

  irqn_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (bus_wr),
    .rd_i    (bus_rd),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .rdata_o (bus_rdata),
    .cfg_o   (cfg),
    .chg_o   (chg)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    irqn_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .pin_i (ext_irq[i]),
      .cfg_i (cfg[i]),
      .chg_i (chg[i]),
      .irq_o (irq_out[i])
    );
  end

  // R1: outputs are low in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && bus_rdata == '0));
endmodule

// File: tb/irq_polarity_norm_tb.sv
module irq_polarity_norm_tb;
  localparam int NCH = 2;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] ext_irq = '0;
  logic [NCH-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int          kind;   // 0: request line, 1: read data
    int          ch;
    logic [31:0] val;
    int          at;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_polarity_norm #(.NCH(NCH), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_irq(ext_irq), .irq_out(irq_out)
  );

  task automatic compare(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // monitor: pops scoreboard items due in this cycle
  always @(negedge clk) begin
    int i;
    i = 0;
    while (i < sb.size()) begin
      if (sb[i].at <= cyc) begin
        if (sb[i].at < cyc)
          compare({sb[i].tag, " (missed)"}, 32'hDEAD, 32'h0);
        else if (sb[i].kind == 0)
          compare(sb[i].tag, 32'(irq_out[sb[i].ch]), sb[i].val);
        else
          compare(sb[i].tag, bus_rdata, sb[i].val);
        sb.delete(i);
      end else begin
        i++;
      end
    end
  end

  task automatic push(int kind, int ch, logic [31:0] val, int d, string tag);
    exp_t e;
    e.kind = kind; e.ch = ch; e.val = val; e.at = cyc + d; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic exp_span(int ch, logic v, int d0, int d1, string tag);
    for (int d = d0; d <= d1; d++) push(0, ch, 32'(v), d, tag);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    bus_rd = 1'b1; bus_addr = a;
    push(1, 0, exp, 1, tag);
    step(1);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    // R1: reset state
    compare("R1 irq after reset", 32'(irq_out), 32'h0);
    rd(8'h04, 32'h0, "R1 ch0 cfg reset");
    rd(8'h08, 32'h0, "R1 ch1 cfg reset");
    step(2);

    // R2: field storage and reserved bits
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0001_0300, "R2 ch0 readback");
    wr(8'h08, 32'h0000_0100);
    rd(8'h08, 32'h0000_0100, "R2 ch1 readback");
    push(1, 0, 32'h0, 2, "R2 idle bus zero");
    step(3);
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h0);

    // R3: unmapped, global and misaligned addresses
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0, "R3 global reads zero");
    rd(8'h0C, 32'h0, "R3 past last channel");
    rd(8'h05, 32'h0, "R3 misaligned");
    rd(8'h04, 32'h0, "R3 ch0 untouched");
    rd(8'h08, 32'h0, "R3 ch1 untouched");
    step(3);

    // R4: level active high on ch0
    wr(8'h04, 32'h0001_0300);
    step(4);
    ext_irq[0] = 1'b1;
    push(0, 0, 0, 2, "R4 before latency");
    exp_span(0, 1'b1, 3, 7, "R4 level high held");
    exp_span(1, 1'b0, 1, 7, "R10 ch1 unaffected");
    step(8);
    ext_irq[0] = 1'b0;
    push(0, 0, 1, 2, "R4 release latency");
    exp_span(0, 1'b0, 3, 5, "R4 level high released");
    step(6);

    // R5: level active low on ch1, pin low
    wr(8'h08, 32'h0001_0200);
    exp_span(1, 1'b1, 1, 4, "R5 low pin active");
    step(5);
    ext_irq[1] = 1'b1;
    push(0, 1, 1, 2, "R5 before latency");
    exp_span(1, 1'b0, 3, 5, "R5 high pin idle");
    step(6);
    ext_irq[1] = 1'b0;
    exp_span(1, 1'b1, 3, 4, "R5 low again");
    step(5);
    wr(8'h08, 32'h0);
    step(3);

    // R6: rising edge on ch0
    wr(8'h04, 32'h0001_0000);
    step(4);
    ext_irq[0] = 1'b1;
    push(0, 0, 0, 2, "R6 before latency");
    push(0, 0, 1, 3, "R6 rising pulse");
    exp_span(0, 1'b0, 4, 7, "R6 pulse width one");
    step(8);
    ext_irq[0] = 1'b0;
    exp_span(0, 1'b0, 1, 6, "R6 falling ignored");
    step(7);

    // R7: falling edge on ch1
    wr(8'h08, 32'h0001_0100);
    exp_span(1, 1'b0, 1, 4, "R7 enable quiet");
    step(5);
    ext_irq[1] = 1'b1;
    exp_span(1, 1'b0, 1, 6, "R7 rising ignored");
    step(7);
    ext_irq[1] = 1'b0;
    push(0, 1, 1, 3, "R7 falling pulse");
    exp_span(1, 1'b0, 4, 6, "R7 pulse width one");
    step(7);

    // R8: masked level and edge on ch0
    wr(8'h04, 32'h0000_0300);
    step(2);
    ext_irq[0] = 1'b1;
    exp_span(0, 1'b0, 1, 6, "R8 masked level");
    step(7);
    wr(8'h04, 32'h0000_0000);
    ext_irq[0] = 1'b0;
    exp_span(0, 1'b0, 1, 6, "R8 masked edge");
    step(3);
    ext_irq[0] = 1'b1;
    exp_span(0, 1'b0, 1, 6, "R8 masked edge rise");
    step(7);
    ext_irq[0] = 1'b0;
    step(5);

    // R9: reconfigure rising to falling with pin low
    wr(8'h04, 32'h0001_0000);
    step(5);
    wr(8'h04, 32'h0001_0100);
    exp_span(0, 1'b0, 0 + 1, 6, "R9 no false pulse");
    step(7);
    ext_irq[0] = 1'b1;
    exp_span(0, 1'b0, 1, 6, "R9 rise ignored after reprogram");
    step(7);
    ext_irq[0] = 1'b0;
    push(0, 0, 1, 3, "R9 falling pulse after reprogram");
    step(6);

    // R10: both channels at once, ch0 rising edge, ch1 level high
    wr(8'h04, 32'h0001_0000);
    wr(8'h08, 32'h0001_0300);
    step(5);
    ext_irq = 2'b11;
    push(0, 0, 1, 3, "R10 ch0 pulse");
    push(0, 0, 0, 4, "R10 ch0 single");
    exp_span(1, 1'b1, 3, 6, "R10 ch1 level");
    step(8);
    ext_irq = 2'b00;
    step(10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule